// File: doc/BRIEF.md
# Window Watchdog Timer

This block supervises software by counting a 7-bit value down at a slow, programmable rate. The rate is the peripheral clock divided first by a fixed power of two, 2^BASE_DIV_LOG2 (4096 by default), and then by a selectable power of two from 1 to 128. Software must reload the count inside a permitted window. A reload that comes while the count is still above the programmed window value is a fault. Letting the count fall through its floor of 0x40 is also a fault. Either fault sends a one-cycle reset request to the system reset controller.

An early-warning flag rises when the count steps down onto the floor value, one step before the timeout reset. The flag can be routed to an interrupt output. Three word-addressed registers on a simple write strobe / combinational read port hold the counter and enable, the window, rate and interrupt enable, and the warning flag.

Top module: `window_watchdog`

## Requirements
- R1: After reset, a read at address 0x0 returns 0x7F (disabled, count 0x7F), a read at 0x4 returns 0x7F (window 0x7F, rate select 0, interrupt enable 0), a read at 0x8 returns 0, and both `rst_req` and `irq_early` are low.
- R2: The count (address 0x0, bits 6:0) decrements by one every 2^(BASE_DIV_LOG2 + sel) clocks, where sel is address 0x4 bits 13:11. A write to address 0x0 loads the count and restarts this period, so the first decrement lands exactly one period after the write edge.
- R3: The enable bit (address 0x0, bit 7) is set by writing 1 to it. Writing 0 to it leaves it set until the reset input is asserted.
- R4: While enabled, a decrement from 0x40 to 0x3F raises `rst_req` on the clock edge of that decrement. While disabled, the count still decrements but `rst_req` never rises.
- R5: A write to address 0x0 whose bit 6 is 0 raises `rst_req` at the write edge when the block is enabled, or becomes enabled by that same write.
- R6: A write to address 0x0 while enabled and while the current count is above the window (address 0x4, bits 6:0) raises `rst_req`. When the count equals or is below the window, the write does not.
- R7: The warning flag (address 0x8, bit 0) is set on the edge where the count steps from 0x41 to 0x40, whether or not the interrupt is enabled. `irq_early` equals the flag ANDed with the interrupt enable.
- R8: Writing address 0x8 with bit 0 equal to 0 clears the warning flag. Writing it with bit 0 equal to 1 leaves the flag unchanged.
- R9: The interrupt enable (address 0x4, bit 9) is set by writing 1 and stays set when later written with 0.
- R10: `rst_req` is registered: it is high for exactly the one cycle following each faulting edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset from the system reset controller |
| bus_wr | input | 1 | Write strobe, one register write per cycle it is high |
| bus_addr | input | ADDR_W | Register byte address (0x0, 0x4, 0x8) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| rst_req | output | 1 | One-cycle system reset request |
| irq_early | output | 1 | Early-warning interrupt, level |

## Verification
The bench targets the exact decrement cycle after a reload. A design that failed to restart the divider on a write would show the count one step low or high at the sampled cycle. The window test reloads at counts one above and exactly at the window value, so an off-by-one in the comparison shows up as a missing or spurious reset pulse. The bench runs the count through 0x40 while disabled, which catches a reset raised without enable. It also checks that the warning flag still sets with the interrupt off and that a written 1 does not clear it. It then times the timeout pulse to the single cycle after the 0x40-to-0x3F edge, where a late, early or stretched pulse fails.

// File: rtl/wwd_pkg.sv
package wwd_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL,
    SEL_CFG,
    SEL_STAT,
    SEL_NONE
  } wwd_sel_e;

  localparam int OFS_CTRL      = 'h0;
  localparam int OFS_CFG       = 'h4;
  localparam int OFS_STAT      = 'h8;
  localparam int CTRL_EN_BIT   = 7;
  localparam int CFG_IRQEN_BIT = 9;
  localparam int CFG_SEL_LSB   = 11;
  localparam int STAT_WARN_BIT = 0;

  function automatic wwd_sel_e decode_offset(input int ofs);
    case (ofs)
      OFS_CTRL: return SEL_CTRL;
      OFS_CFG:  return SEL_CFG;
      OFS_STAT: return SEL_STAT;
      default:  return SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/wwd_prescaler.sv
module wwd_prescaler #(
  parameter int BASE_DIV_LOG2 = 12,
  parameter int SEL_W         = 3,
  localparam int PW           = BASE_DIV_LOG2 + (1 << SEL_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [SEL_W-1:0] rate_sel,
  output logic             tick
);

  logic [PW-1:0] phase_q;
  logic [PW-1:0] last_phase;

  // Terminal phase of a period of 2^(BASE + sel) clocks.
  function automatic logic [PW-1:0] terminal_phase(input logic [SEL_W-1:0] sel);
    return ~({PW{1'b1}} << (BASE_DIV_LOG2 + int'(sel)));
  endfunction

  assign last_phase = terminal_phase(rate_sel);
  assign tick       = (phase_q == last_phase);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (restart || tick) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R2

  AST_RESTART_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !tick); // R2

endmodule

// File: rtl/wwd_counter.sv
module wwd_counter #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             en_set,
  input  logic [CNT_W-1:0] window,
  output logic [CNT_W-1:0] count,
  output logic             enabled,
  output logic             warn_evt,
  output logic             rst_req
);

  localparam logic [CNT_W-1:0] FLOOR   = CNT_W'(1) << (CNT_W - 1);
  localparam logic [CNT_W-1:0] WARN_AT = FLOOR + 1'b1;

  logic [CNT_W-1:0] cnt_q;
  logic             en_q;
  logic             rst_req_q;
  logic             step;
  logic             en_after;
  logic             early_fault;
  logic             low_fault;
  logic             timeout_fault;
  logic             any_fault;

  function automatic logic above_window(input logic [CNT_W-1:0] c,
                                        input logic [CNT_W-1:0] w);
    return c > w;
  endfunction

  function automatic logic under_floor(input logic [CNT_W-1:0] v);
    return !v[CNT_W-1];
  endfunction

  assign step          = tick && !load;
  assign en_after      = en_q || (load && en_set);
  assign early_fault   = load && en_q && above_window(cnt_q, window);
  assign low_fault     = load && en_after && under_floor(load_val);
  assign timeout_fault = step && en_q && (cnt_q == FLOOR);
  assign any_fault     = early_fault || low_fault || timeout_fault;
  assign warn_evt      = step && (cnt_q == WARN_AT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '1;
      en_q      <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      en_q      <= en_after;
      rst_req_q <= any_fault;
      if (load) begin
        cnt_q <= load_val;
      end else if (tick) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign count   = cnt_q;
  assign enabled = en_q;
  assign rst_req = rst_req_q;

  AST_EN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> en_q); // R3

  AST_TICK_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (cnt_q == CNT_W'($past(cnt_q) - 1'b1))); // R2

  AST_RST_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_q |-> en_q); // R4

  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val))); // R6

endmodule

// File: rtl/window_watchdog.sv
module window_watchdog
  import wwd_pkg::*;
#(
  parameter int BASE_DIV_LOG2 = 12,
  parameter int CNT_W         = 7,
  parameter int SEL_W         = 3,
  parameter int ADDR_W        = 4,
  parameter int DATA_W        = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              rst_req,
  output logic              irq_early
);

  wwd_sel_e         sel;
  logic             wr_ctrl, wr_cfg, wr_stat;
  logic [CNT_W-1:0] window_q;
  logic [SEL_W-1:0] rate_q;
  logic             irqen_q;
  logic             warn_q;
  logic             tick;
  logic             warn_evt;
  logic [CNT_W-1:0] count;
  logic             enabled;
  logic             unused_wdata;

  assign sel     = decode_offset(int'(bus_addr));
  assign wr_ctrl = bus_wr && (sel == SEL_CTRL);
  assign wr_cfg  = bus_wr && (sel == SEL_CFG);
  assign wr_stat = bus_wr && (sel == SEL_STAT);
  assign unused_wdata = &{1'b0, bus_wdata};

  wwd_prescaler #(
    .BASE_DIV_LOG2 (BASE_DIV_LOG2),
    .SEL_W         (SEL_W)
  ) u_presc (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (wr_ctrl),
    .rate_sel (rate_q),
    .tick     (tick)
  );

  wwd_counter #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .load     (wr_ctrl),
    .load_val (bus_wdata[CNT_W-1:0]),
    .en_set   (bus_wdata[CTRL_EN_BIT]),
    .window   (window_q),
    .count    (count),
    .enabled  (enabled),
    .warn_evt (warn_evt),
    .rst_req  (rst_req)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      window_q <= '1;
      rate_q   <= '0;
      irqen_q  <= 1'b0;
      warn_q   <= 1'b0;
    end else begin
      if (wr_cfg) begin
        window_q <= bus_wdata[CNT_W-1:0];
        rate_q   <= bus_wdata[CFG_SEL_LSB +: SEL_W];
        irqen_q  <= irqen_q || bus_wdata[CFG_IRQEN_BIT];
      end
      if (warn_evt) begin
        warn_q <= 1'b1;
      end else if (wr_stat && !bus_wdata[STAT_WARN_BIT]) begin
        warn_q <= 1'b0;
      end
    end
  end

  assign irq_early = warn_q && irqen_q;

  always_comb begin
    bus_rdata = '0;
    case (sel)
      SEL_CTRL: begin
        bus_rdata[CNT_W-1:0]   = count;
        bus_rdata[CTRL_EN_BIT] = enabled;
      end
      SEL_CFG: begin
        bus_rdata[CNT_W-1:0]             = window_q;
        bus_rdata[CFG_IRQEN_BIT]         = irqen_q;
        bus_rdata[CFG_SEL_LSB +: SEL_W]  = rate_q;
      end
      SEL_STAT: bus_rdata[STAT_WARN_BIT] = warn_q;
      default:  bus_rdata = '0;
    endcase
  end

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq_early |-> warn_q); // R7

  AST_FLAG_AT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(warn_q) |-> (count == (CNT_W'(1) << (CNT_W - 1)))); // R7

  AST_FLAG_CLEAR_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(warn_q) |-> $past(wr_stat && !bus_wdata[STAT_WARN_BIT])); // R8

  AST_IRQEN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    irqen_q |=> irqen_q); // R9

endmodule

// File: tb/test_window_watchdog.sv
`timescale 1ns/1ps
module test_window_watchdog;

  localparam int BASE = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rst_req;
  logic        irq_early;

  int n_checks = 0;
  int n_fail   = 0;
  int pulse_cnt = 0;
  bit pulse_seen;
  bit done = 0;

  always #2 clk = ~clk;

  window_watchdog #(.BASE_DIV_LOG2(BASE)) i_window_watchdog (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rst_req(rst_req), .irq_early(irq_early)
  );

  always @(posedge clk) begin
    #1;
    if (rst_req) pulse_cnt++;
  end

  function automatic int period(input int sel);
    return (1 << BASE) << sel;
  endfunction

  function automatic int exp_count(input int reload, input int edges, input int sel);
    return (reload - edges / period(sel)) & 'h7F;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic write_reg(input int a, input int d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = 32'(d);
    @(posedge clk); #1;
    pulse_seen = rst_req;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic read_reg(input int a, output int d);
    @(negedge clk);
    bus_addr = 4'(a); #1;
    d = int'(bus_rdata);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    int v;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    read_reg('h0, v); check("R1 ctrl", v, 'h7F);
    read_reg('h4, v); check("R1 cfg", v, 'h7F);
    read_reg('h8, v); check("R1 stat", v, 0);
    check("R1 rst_req", rst_req, 0);
    check("R1 irq", irq_early, 0);

    // R2 random rates and reloads while disabled
    for (int i = 0; i < 20; i++) begin
      int sel, rl, n;
      sel = int'($urandom % 4);
      rl  = 8 + int'($urandom % 120);
      n   = int'($urandom % (period(sel) * 8 + 1));
      write_reg('h4, (sel << 11) | 'h7F);
      write_reg('h0, rl);
      repeat (n) @(posedge clk);
      read_reg('h0, v);
      check("R2 count", v, exp_count(rl, n, sel));
    end

    // R2 write restarts the period
    write_reg('h4, 'h7F);
    write_reg('h0, 'h70);
    repeat (2) @(posedge clk);
    write_reg('h0, 'h70);
    repeat (3) @(posedge clk);
    read_reg('h0, v); check("R2 restart hold", v, 'h70);
    repeat (1) @(posedge clk);
    read_reg('h0, v); check("R2 restart step", v, 'h6F);

    // R7 / R8 warning flag while disabled, interrupt off
    write_reg('h8, 0);
    read_reg('h8, v); check("R8 clear", v, 0);
    write_reg('h0, 'h42);
    repeat (8) @(posedge clk);
    read_reg('h0, v); check("R2 at floor", v, 'h40);
    read_reg('h8, v); check("R7 flag set", v, 1);
    check("R7 irq masked", irq_early, 0);
    write_reg('h8, 1);
    read_reg('h8, v); check("R8 write one keeps", v, 1);
    write_reg('h8, 0);
    read_reg('h8, v); check("R8 write zero clears", v, 0);
    repeat (8) @(posedge clk);
    check("R4 no reset while disabled", pulse_cnt, 0);

    // R9 sticky interrupt enable
    write_reg('h4, (1 << 9) | 'h7F);
    write_reg('h4, 'h7F);
    read_reg('h4, v); check("R9 irqen sticky", (v >> 9) & 1, 1);

    // R3 enable and sticky
    write_reg('h0, 'hFF);
    check("R6 legal reload", pulse_seen, 0);
    write_reg('h0, 'h7F);
    check("R6 legal reload 2", pulse_seen, 0);
    read_reg('h0, v); check("R3 enable sticky", (v >> 7) & 1, 1);

    // R4 timeout, R7 irq, R10 pulse width
    write_reg('h0, 'hC2);
    repeat (7) @(posedge clk); #1;
    check("R7 irq before floor", irq_early, 0);
    @(posedge clk); #1;
    check("R7 irq at floor", irq_early, 1);
    repeat (3) @(posedge clk); #1;
    check("R4 no early pulse", rst_req, 0);
    @(posedge clk); #1;
    check("R4 timeout pulse", rst_req, 1);
    @(posedge clk); #1;
    check("R10 pulse one cycle", rst_req, 0);

    // R6 window
    write_reg('h4, (1 << 9) | 'h50);
    write_reg('h0, 'hFF);
    check("R6 below window ok", pulse_seen, 0);
    write_reg('h0, 'hD1);
    check("R6 above window", pulse_seen, 1);
    @(posedge clk); #1;
    check("R10 window pulse one cycle", rst_req, 0);
    write_reg('h0, 'hD1);
    check("R6 one above window", pulse_seen, 1);
    repeat (4) @(posedge clk);
    write_reg('h0, 'hFF);
    check("R6 at window ok", pulse_seen, 0);

    // R5 load below floor
    write_reg('h4, (1 << 9) | 'h7F);
    write_reg('h0, 'hBF);
    check("R5 low load", pulse_seen, 1);
    @(posedge clk); #1;
    check("R10 low load pulse one cycle", rst_req, 0);

    finish_run();
  end

endmodule